// File: doc/BRIEF.md
# Multidrop UART Receiver with Address Filter

This block is an asynchronous serial receiver for a bus shared by many nodes, such as an RS-485 segment. It takes a receive line and a tick that runs at sixteen times the bit rate. It accepts characters of one start bit, eight or nine data bits sent least significant bit first, and one stop bit. Finished characters go into a two-entry receive queue. Each entry keeps its ninth bit and its framing status next to the data.

On a multidrop bus the ninth bit marks a character as an address. While the address filter is on and nine-bit mode is selected, the receiver keeps only characters whose ninth bit is set. All other characters are discarded silently. Software reads an address, compares it with its own, and turns the filter off to receive the message that follows. When the message is over, software turns the filter back on.

The oldest queue entry always appears on the head outputs. The ninth bit and the framing flag can therefore be read before the pop strobe removes the entry. Clearing the receiver enable clears the overrun flag and returns the bit engine to idle. The queue contents are kept.

Top module: `mdrop_uart_rx`

## Requirements
- R1: In eight-bit mode a character is one low start bit, eight data bits sent LSB first, and one stop bit. The stored entry carries those eight bits on head_data, and head_bit9 is 0.
- R2: In nine-bit mode nine data bits are shifted in. The last one received is the ninth (most significant) bit and appears on head_bit9 with its entry.
- R3: The head outputs show the oldest unread entry. A one-cycle pop removes it and brings the next entry forward. A pop while the queue is empty has no effect.
- R4: With nine-bit mode and address filter both on, a character whose ninth bit is 0 is discarded and leaves rx_ready, the queue and the flags unchanged. A character whose ninth bit is 1 is stored.
- R5: In eight-bit mode the address filter has no effect, and every valid character is stored.
- R6: The filter setting is sampled when the stop bit is evaluated. Clearing the filter during a character, before its stop bit, lets that character in.
- R7: rx_ready is 1 exactly while the queue holds at least one entry.
- R8: irq is 1 exactly when rx_ready and irq_en are both 1.
- R9: The queue holds two entries. A character that completes while the queue is full is dropped and sets overrun. While overrun is set, no further character is received.
- R10: Driving rx_en low clears overrun and returns the receiver to idle, while the stored entries remain. Characters sent while rx_en is low are not received.
- R11: Each bit is decided by a majority of three samples at its middle, so a single-tick spike does not corrupt it. A start bit that reads high at its middle is ignored.
- R12: A stop bit sampled low stores the entry with head_ferr set. The flag belongs to that entry and is gone once the entry is popped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx | input | 1 | Serial receive line, idle high |
| rx_en | input | 1 | Receiver enable; low clears overrun and idles the receiver |
| nine_bit_en | input | 1 | Select nine data bits per character |
| addr_filt_en | input | 1 | Keep only characters with ninth bit 1 (nine-bit mode only) |
| irq_en | input | 1 | Receive interrupt enable |
| pop | input | 1 | Remove the head entry |
| head_data | output | 8 | Low eight data bits of the oldest entry |
| head_bit9 | output | 1 | Ninth data bit of the oldest entry |
| head_ferr | output | 1 | Framing error of the oldest entry |
| rx_ready | output | 1 | Queue not empty |
| irq | output | 1 | Receive interrupt |
| overrun | output | 1 | A character was lost because the queue was full |

## Verification
A bad sample counter or bit index shows up on the head outputs as a shifted or truncated byte, or as a false framing flag, one character time after the error. A wrong filter decision appears within the same character as an extra or missing rx_ready edge. A queue-pointer or count fault shows up at the next pop or at the third queued character: entries come out in the wrong order, or overrun rises at the wrong time. Random mode, filter and data mixes are compared entry by entry against a queue model, along with directed spike, glitch, framing, overrun and late-filter-release cases.

// File: rtl/mdrop_uart_rx.sv
module mdrop_uart_rx #(
  parameter int OVS   = 16,
  parameter int DEPTH = 2   // power of two
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       rx,
  input  logic       rx_en,
  input  logic       nine_bit_en,
  input  logic       addr_filt_en,
  input  logic       irq_en,
  input  logic       pop,
  output logic [7:0] head_data,
  output logic       head_bit9,
  output logic       head_ferr,
  output logic       rx_ready,
  output logic       irq,
  output logic       overrun
);

  localparam int CW = $clog2(OVS);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] T_S0  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] T_S1  = CW'(OVS / 2);
  localparam logic [CW-1:0] T_V   = CW'(OVS / 2 + 1);
  localparam logic [CW-1:0] T_END = CW'(OVS - 1);
  localparam logic [AW:0]   FULL_N = (AW + 1)'(DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t             st;
  logic            rx_m, rx_s, s0, s1, mode9;
  logic [CW-1:0]   tcnt;
  logic [3:0]      bidx;
  logic [8:0]      sr;
  logic [9:0]      mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [AW:0]     cnt;
  logic            vote, done, ch_b9, keep, full, push, do_pop;
  logic [7:0]      ch_data;

  assign vote    = (s0 & s1) | (s0 & rx_s) | (s1 & rx_s);
  assign done    = rx_en && !overrun && baud_tick && st == S_STOP && tcnt == T_V;
  assign ch_data = mode9 ? sr[7:0] : sr[8:1];
  assign ch_b9   = mode9 & sr[8];
  assign keep    = !(mode9 && addr_filt_en && !ch_b9);
  assign full    = cnt == FULL_N;
  assign push    = done && keep && !full;
  assign do_pop  = pop && cnt != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rx;
      rx_s <= rx_m;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      tcnt  <= '0;
      bidx  <= '0;
      sr    <= '0;
      s0    <= 1'b1;
      s1    <= 1'b1;
      mode9 <= 1'b0;
    end else if (!rx_en || overrun) begin
      st   <= S_IDLE;
      tcnt <= '0;
    end else if (baud_tick) begin
      if (st == S_IDLE) begin
        tcnt <= '0;
        if (!rx_s) begin
          st    <= S_START;
          mode9 <= nine_bit_en;
        end
      end else begin
        tcnt <= (tcnt == T_END) ? '0 : tcnt + 1'b1;
        if (tcnt == T_S0) s0 <= rx_s;
        if (tcnt == T_S1) s1 <= rx_s;
        case (st)
          S_START: begin
            if (tcnt == T_V && vote) st <= S_IDLE;
            else if (tcnt == T_END) begin
              st   <= S_DATA;
              bidx <= '0;
            end
          end
          S_DATA: begin
            if (tcnt == T_V) sr <= {vote, sr[8:1]};
            if (tcnt == T_END) begin
              if (bidx == (mode9 ? 4'd8 : 4'd7)) st <= S_STOP;
              else bidx <= bidx + 4'd1;
            end
          end
          S_STOP: if (tcnt == T_V) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {!vote, ch_b9, ch_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      overrun <= 1'b0;
    end else begin
      if (push)   wp <= wp + 1'b1;
      if (do_pop) rp <= rp + 1'b1;
      case ({push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (!rx_en) overrun <= 1'b0;
      else if (done && keep && full) overrun <= 1'b1;
    end
  end

  assign {head_ferr, head_bit9, head_data} = mem[rp];
  assign rx_ready = cnt != '0;
  assign irq      = rx_ready & irq_en;

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_N);

  // R9
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && keep && full) |=> overrun);

  // R9
  ovr_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> st == S_IDLE);

  // R10
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !overrun);

  // R4
  filter_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode9 && addr_filt_en && !sr[8] && !pop) |=> ($stable(cnt) && $stable(wp)));

  // R5
  eight_bit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode9 && !full && !pop) |=> cnt == $past(cnt) + 1'b1);

  // R3
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !push) |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: tb/tb_mdrop_uart_rx.sv
`timescale 1ns/1ps
module tb_mdrop_uart_rx;
  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1, rx_en = 1'b0;
  logic nine = 1'b0, filt = 1'b0, irq_en = 1'b0, pop = 1'b0;
  logic [1:0] tdiv = '0;
  logic baud_tick;
  logic [7:0] head_data;
  logic head_bit9, head_ferr, rx_ready, irq, overrun;

  int nchk = 0, nfail = 0;
  bit [9:0] q[$];
  bit ovr_m = 1'b0;

  always #4 clk = ~clk;
  always_ff @(posedge clk) tdiv <= tdiv + 2'd1;
  assign baud_tick = (tdiv == 2'd3);

  mdrop_uart_rx dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx(rx), .rx_en(rx_en),
    .nine_bit_en(nine), .addr_filt_en(filt), .irq_en(irq_en), .pop(pop),
    .head_data(head_data), .head_bit9(head_bit9), .head_ferr(head_ferr),
    .rx_ready(rx_ready), .irq(irq), .overrun(overrun)
  );

  function automatic bit keeps(bit m9, bit f, bit b9);
    return !(m9 && f && !b9);
  endfunction

  function automatic bit [9:0] entry(bit [8:0] d, bit m9, bit fe);
    return {fe, m9 & d[8], d[7:0]};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bit_time(bit v, bit spike);
    rx = v;
    if (spike) begin
      repeat (30) @(negedge clk);
      rx = ~v;
      repeat (4) @(negedge clk);
      rx = v;
      repeat (30) @(negedge clk);
    end else begin
      repeat (64) @(negedge clk);
    end
  endtask

  task automatic send(bit [8:0] d, bit stop_v, bit unfilt, bit spike);
    bit m9;
    bit fat;
    int nb;
    m9 = nine;
    nb = m9 ? 9 : 8;
    bit_time(1'b0, 1'b0);
    for (int i = 0; i < nb; i++) bit_time(d[i], spike && i == 0);
    if (unfilt) filt = 1'b0;
    fat = filt;
    bit_time(stop_v, 1'b0);
    bit_time(1'b1, 1'b0);
    if (rx_en && !ovr_m && keeps(m9, fat, d[8])) begin
      if (q.size() < 2) q.push_back(entry(d, m9, !stop_v));
      else ovr_m = 1'b1;
    end
  endtask

  task automatic check_all(string tag);
    bit er;
    er = q.size() != 0;
    chk(rx_ready == er, "R7", rx_ready, er);
    chk(irq == (er && irq_en), "R8", irq, er && irq_en);
    chk(overrun == ovr_m, "R9", overrun, ovr_m);
    if (er) chk({head_ferr, head_bit9, head_data} == q[0], tag,
                {head_ferr, head_bit9, head_data}, q[0]);
  endtask

  task automatic do_pop();
    @(negedge clk) pop = 1'b1;
    @(negedge clk) pop = 1'b0;
    if (q.size() != 0) q.delete(0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check_all("R7");
    chk(overrun == 1'b0, "R9", overrun, 0);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);

    // R1 eight-bit character
    nine = 1'b0;
    send(9'h0A5, 1'b1, 1'b0, 1'b0);
    check_all("R1");
    chk(head_bit9 == 1'b0, "R1", head_bit9, 0);
    do_pop();
    check_all("R3");

    // R2 nine-bit character
    nine = 1'b1;
    send(9'h13C, 1'b1, 1'b0, 1'b0);
    check_all("R2");
    chk(head_bit9 == 1'b1, "R2", head_bit9, 1);
    do_pop();

    // R4 address filter
    filt = 1'b1;
    send(9'h055, 1'b1, 1'b0, 1'b0);
    check_all("R4");
    chk(rx_ready == 1'b0, "R4", rx_ready, 0);
    send(9'h1A0, 1'b1, 1'b0, 1'b0);
    check_all("R4");
    do_pop();

    // R5 filter ignored in eight-bit mode
    nine = 1'b0;
    send(9'h033, 1'b1, 1'b0, 1'b0);
    check_all("R5");
    chk(rx_ready == 1'b1, "R5", rx_ready, 1);
    do_pop();

    // R6 filter released before stop bit
    nine = 1'b1;
    filt = 1'b1;
    send(9'h0C3, 1'b1, 1'b1, 1'b0);
    check_all("R6");
    chk(rx_ready == 1'b1, "R6", rx_ready, 1);
    do_pop();

    // R12 framing error per entry
    filt = 1'b0;
    send(9'h07E, 1'b0, 1'b0, 1'b0);
    check_all("R12");
    chk(head_ferr == 1'b1, "R12", head_ferr, 1);
    send(9'h081, 1'b1, 1'b0, 1'b0);
    do_pop();
    check_all("R12");
    chk(head_ferr == 1'b0, "R12", head_ferr, 0);
    do_pop();

    // R11 start glitch and mid-bit spike
    @(negedge clk) rx = 1'b0;
    repeat (12) @(negedge clk);
    rx = 1'b1;
    repeat (128) @(negedge clk);
    check_all("R11");
    chk(rx_ready == 1'b0, "R11", rx_ready, 0);
    send(9'h0F0, 1'b1, 1'b0, 1'b1);
    check_all("R11");
    send(9'h00F, 1'b1, 1'b0, 1'b1);
    do_pop();
    check_all("R11");
    do_pop();

    // R8 interrupt gating
    irq_en = 1'b1;
    send(9'h1EE, 1'b1, 1'b0, 1'b0);
    check_all("R8");
    chk(irq == 1'b1, "R8", irq, 1);
    @(negedge clk) irq_en = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R8", irq, 0);
    irq_en = 1'b1;
    do_pop();
    chk(irq == 1'b0, "R8", irq, 0);

    // R9 overrun
    send(9'h011, 1'b1, 1'b0, 1'b0);
    send(9'h122, 1'b1, 1'b0, 1'b0);
    send(9'h033, 1'b1, 1'b0, 1'b0);
    check_all("R9");
    chk(overrun == 1'b1, "R9", overrun, 1);
    send(9'h044, 1'b1, 1'b0, 1'b0);
    check_all("R9");

    // R10 enable low clears overrun, keeps entries
    @(negedge clk) rx_en = 1'b0;
    @(negedge clk) rx_en = 1'b1;
    ovr_m = 1'b0;
    @(negedge clk);
    check_all("R10");
    chk(overrun == 1'b0, "R10", overrun, 0);
    do_pop();
    check_all("R10");
    do_pop();
    rx_en = 1'b0;
    send(9'h05A, 1'b1, 1'b0, 1'b0);
    check_all("R10");
    chk(rx_ready == 1'b0, "R10", rx_ready, 0);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);

    // R3 pop on empty queue
    do_pop();
    check_all("R3");
    chk(rx_ready == 1'b0, "R3", rx_ready, 0);
    send(9'h0E1, 1'b1, 1'b0, 1'b0);
    check_all("R3");
    do_pop();

    // random mix
    for (int n = 0; n < 40; n++) begin
      bit [8:0] d;
      bit sv, uf;
      nine   = 1'($urandom % 2);
      filt   = 1'($urandom % 2);
      irq_en = 1'($urandom % 2);
      d      = 9'($urandom);
      sv     = ($urandom % 8) != 0;
      uf     = filt && ($urandom % 4 == 0);
      send(d, sv, uf, 1'($urandom % 4 == 0));
      check_all(nine ? (filt ? "R4" : "R2") : "R1");
      if (q.size() == 2 || ($urandom % 2) == 1) begin
        do_pop();
        check_all("R3");
      end
    end

    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end
endmodule